// File: doc/BRIEF.md
# Cipher Mode and Key Validator

This block sits in front of a stream-cipher and integrity execution unit. It holds the settings software writes for a job: the function select, the first-block and last-block flags, the integrity-compare enable, two mutually exclusive framing flags, and the key length in bytes. On a start strobe it checks those settings. If they are legal, it launches the job. If they are not, it refuses the job and records why.

After the integrity function finishes, the unit presents its computed check value together with the expected value. When comparison is enabled, the block flags any difference. Error causes collect in a sticky one-hot vector that drives an interrupt line until software clears it.

Top module: `cipher_mode_guard`

## Requirements
- R1: A key-length write carrying a value above 16 is ignored: `key_size` keeps its old value. Writes from 0 to 16 are stored and appear on `key_size` one cycle later.
- R2: `key_size` is 0 during reset and in the cycle after a `reinit` pulse. `reinit` takes priority over a key-length write in the same cycle.
- R3: A start with legal settings raises `job_go` for exactly one cycle, one cycle after `start`. Legal settings mean a function code of 00 or 10, a key length of exactly 16, and not both framing flags set.
- R4: A start with function code 00 or 10 and a stored key length other than 16 sets `err_cause[0]` one cycle later and raises no `job_go`.
- R5: A start with function code 01 or 11 sets `err_cause[1]` one cycle later and raises no `job_go`. It does not set `err_cause[0]`, whatever the key length.
- R6: A start with both `mode_edge` and `mode_gsm` stored set sets `err_cause[2]` one cycle later and raises no `job_go`.
- R7: An `icv_valid` cycle with `icv_calc` different from `icv_exp` sets `err_cause[3]` one cycle later. This happens only when the compare flag is stored set and the function code is 10. In every other case, and whenever the values match, `icv_valid` leaves `err_cause` unchanged.
- R8: `err_cause` bits stay set and accumulate until an `err_clr` cycle clears them. A cause raised in the same cycle as `err_clr` survives. `err_irq` is high exactly when `err_cause` is nonzero.
- R9: In the `job_go` cycle, `job_init` equals the stored first-block flag. It is 0 in all other cycles.
- R10: In the `job_go` cycle, `job_final` is 1 only if the stored last-block flag is set and the function code is 10 (integrity). It is 0 in all other cycles.
- R11: A start checks the settings stored before that clock edge. A mode or key write in the same cycle takes effect only for later starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the mode settings |
| mode_alg | input | 2 | Function code: 00 confidentiality, 10 integrity, 01/11 reserved |
| mode_init | input | 1 | First-block flag |
| mode_final | input | 1 | Last-block flag |
| mode_icv_cmp | input | 1 | Integrity compare enable |
| mode_edge | input | 1 | Framing flag A |
| mode_gsm | input | 1 | Framing flag B, exclusive with A |
| ksz_we | input | 1 | Key-length write strobe |
| ksz_wdata | input | KW | Key length in bytes |
| reinit | input | 1 | Unit re-initialization pulse |
| start | input | 1 | Job start strobe |
| icv_valid | input | 1 | Check values present |
| icv_calc | input | ICV_W | Computed check value |
| icv_exp | input | ICV_W | Expected check value |
| err_clr | input | 1 | Clears the error causes |
| key_size | output | KW | Stored key length |
| job_go | output | 1 | Job launched |
| job_init | output | 1 | Launched job initializes a new message |
| job_final | output | 1 | Launched job finalizes the integrity message |
| err_irq | output | 1 | Error interrupt |
| err_cause | output | 4 | One-hot causes: [0] key length, [1] reserved code, [2] framing conflict, [3] check mismatch |

## Verification
The bench targets several boundary cases, and each names the fault it would expose. An over-range key length of 17 catches a design that stores it instead of ignoring it. A `reinit` in the same cycle as a key write catches a design that lets the write win. Reserved codes paired with a wrong key length catch a design that reports a key error alongside the mode error. A check-value mismatch sent under the confidentiality function, or with compare disabled, catches a design that raises a false mismatch. A clear in the same cycle as a fresh error catches a design that drops the new cause. The last-block flag under the confidentiality function catches a design that requests final processing outside the integrity function.

// File: rtl/cipher_mode_guard.sv
`timescale 1ns/1ps
module cipher_mode_guard #(
  parameter int ICV_W = 32,
  parameter int KEY_BYTES = 16,
  localparam int KW = $clog2(KEY_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [1:0]       mode_alg,
  input  logic             mode_init,
  input  logic             mode_final,
  input  logic             mode_icv_cmp,
  input  logic             mode_edge,
  input  logic             mode_gsm,
  input  logic             ksz_we,
  input  logic [KW-1:0]    ksz_wdata,
  input  logic             reinit,
  input  logic             start,
  input  logic             icv_valid,
  input  logic [ICV_W-1:0] icv_calc,
  input  logic [ICV_W-1:0] icv_exp,
  input  logic             err_clr,
  output logic [KW-1:0]    key_size,
  output logic             job_go,
  output logic             job_init,
  output logic             job_final,
  output logic             err_irq,
  output logic [3:0]       err_cause
);

  localparam logic [KW-1:0] KEY_MAX = KW'(KEY_BYTES);

  logic [1:0] alg_q;
  logic       init_q, final_q, cmp_q, edge_q, gsm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alg_q   <= 2'b00;
      init_q  <= 1'b0;
      final_q <= 1'b0;
      cmp_q   <= 1'b0;
      edge_q  <= 1'b0;
      gsm_q   <= 1'b0;
    end else if (mode_we) begin
      alg_q   <= mode_alg;
      init_q  <= mode_init;
      final_q <= mode_final;
      cmp_q   <= mode_icv_cmp;
      edge_q  <= mode_edge;
      gsm_q   <= mode_gsm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || reinit)
      key_size <= '0;
    else if (ksz_we && ksz_wdata <= KEY_MAX)
      key_size <= ksz_wdata;
  end

  wire alg_rsv  = alg_q[0];
  wire is_integ = (alg_q == 2'b10);
  wire bad_key  = !alg_rsv && (key_size != KEY_MAX);
  wire conflict = edge_q && gsm_q;
  wire legal    = !alg_rsv && !bad_key && !conflict;

  wire [3:0] raise = {icv_valid && cmp_q && is_integ && (icv_calc != icv_exp),
                      start && conflict,
                      start && alg_rsv,
                      start && bad_key};
  wire [3:0] cause_d = (err_clr ? 4'b0000 : err_cause) | raise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cause <= 4'b0000;
      err_irq   <= 1'b0;
      job_go    <= 1'b0;
      job_init  <= 1'b0;
      job_final <= 1'b0;
    end else begin
      err_cause <= cause_d;
      err_irq   <= |cause_d;
      job_go    <= start && legal;
      job_init  <= start && legal && init_q;
      job_final <= start && legal && final_q && is_integ;
    end
  end

  AST_KEY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    key_size <= KEY_MAX); // R1
  AST_REINIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> key_size == '0); // R2
  AST_BADKEY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && key_size != KEY_MAX) |=> !job_go); // R4
  AST_RSV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && alg_q[0]) |=> (!job_go && err_cause[1])); // R5
  AST_CONFLICT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && edge_q && gsm_q) |=> !job_go); // R6
  AST_ICV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (icv_valid && alg_q != 2'b10 && !err_clr) |=> err_cause[3] == $past(err_cause[3])); // R7
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (err_cause & $past(err_cause)) == $past(err_cause)); // R8
  AST_FINAL_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    job_final |-> job_go); // R10
  AST_INIT_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    job_init |-> job_go); // R9

endmodule

// File: tb/cipher_mode_guard_bench.sv
`timescale 1ns/1ps
module cipher_mode_guard_bench;
  localparam int ICV_W = 32;
  localparam int KW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic mode_we = 0, mode_init = 0, mode_final = 0, mode_icv_cmp = 0, mode_edge = 0, mode_gsm = 0;
  logic [1:0] mode_alg = 0;
  logic ksz_we = 0, reinit = 0, start = 0, icv_valid = 0, err_clr = 0;
  logic [KW-1:0] ksz_wdata = 0;
  logic [ICV_W-1:0] icv_calc = 0, icv_exp = 0;
  logic [KW-1:0] key_size;
  logic job_go, job_init, job_final, err_irq;
  logic [3:0] err_cause;

  cipher_mode_guard #(.ICV_W(ICV_W), .KEY_BYTES(16)) u_cipher_mode_guard (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_alg(mode_alg),
    .mode_init(mode_init), .mode_final(mode_final), .mode_icv_cmp(mode_icv_cmp),
    .mode_edge(mode_edge), .mode_gsm(mode_gsm), .ksz_we(ksz_we), .ksz_wdata(ksz_wdata),
    .reinit(reinit), .start(start), .icv_valid(icv_valid), .icv_calc(icv_calc),
    .icv_exp(icv_exp), .err_clr(err_clr), .key_size(key_size), .job_go(job_go),
    .job_init(job_init), .job_final(job_final), .err_irq(err_irq), .err_cause(err_cause));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int m_ks = 0, m_alg = 0;
  bit m_init = 0, m_fin = 0, m_cmp = 0, m_edge = 0, m_gsm = 0;
  bit m_go = 0, m_ji = 0, m_jf = 0;
  bit [3:0] m_cause = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ks = 0; m_alg = 0; m_init = 0; m_fin = 0; m_cmp = 0; m_edge = 0; m_gsm = 0;
      m_go = 0; m_ji = 0; m_jf = 0; m_cause = 0;
    end else begin
      bit rsv, keybad, clash, ok;
      bit [3:0] nw;
      rsv    = (m_alg == 1) || (m_alg == 3);
      keybad = !rsv && (m_ks != 16);
      clash  = m_edge && m_gsm;
      ok     = start && !rsv && !keybad && !clash;
      nw = 0;
      if (start && keybad) nw[0] = 1;
      if (start && rsv) nw[1] = 1;
      if (start && clash) nw[2] = 1;
      if (icv_valid && m_cmp && m_alg == 2 && icv_calc != icv_exp) nw[3] = 1;
      m_cause = (err_clr ? 4'b0 : m_cause) | nw;
      m_go = ok;
      m_ji = ok && m_init;
      m_jf = ok && m_fin && (m_alg == 2);
      if (reinit) m_ks = 0;
      else if (ksz_we && ksz_wdata <= 16) m_ks = int'(ksz_wdata);
      if (mode_we) begin
        m_alg = int'(mode_alg); m_init = mode_init; m_fin = mode_final;
        m_cmp = mode_icv_cmp; m_edge = mode_edge; m_gsm = mode_gsm;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check("R1 R2 key_size", int'(key_size), m_ks);
      check("R3 job_go", int'(job_go), int'(m_go));
      check("R9 job_init", int'(job_init), int'(m_ji));
      check("R10 job_final", int'(job_final), int'(m_jf));
      check("R4 cause key", int'(err_cause[0]), int'(m_cause[0]));
      check("R5 cause mode", int'(err_cause[1]), int'(m_cause[1]));
      check("R6 cause conflict", int'(err_cause[2]), int'(m_cause[2]));
      check("R7 cause icv", int'(err_cause[3]), int'(m_cause[3]));
      check("R8 err_irq", int'(err_irq), int'(m_cause != 0));
    end
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr_mode(int alg, bit ini, bit fin, bit cmp, bit ed, bit gs);
    mode_alg = 2'(alg); mode_init = ini; mode_final = fin; mode_icv_cmp = cmp;
    mode_edge = ed; mode_gsm = gs; mode_we = 1; cyc(); mode_we = 0;
  endtask

  task automatic wr_key(int v);
    ksz_wdata = KW'(v); ksz_we = 1; cyc(); ksz_we = 0;
  endtask

  task automatic go(); start = 1; cyc(); start = 0; cyc(); endtask
  task automatic clr(); err_clr = 1; cyc(); err_clr = 0; endtask

  task automatic icv(int a, int b);
    icv_calc = ICV_W'(a); icv_exp = ICV_W'(b); icv_valid = 1; cyc(); icv_valid = 0; cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R3 R9 R10: legal integrity job with first and last block
    wr_key(16);
    wr_mode(2, 1, 1, 0, 0, 0);
    go();
    // R10: last-block flag ignored under confidentiality
    wr_mode(0, 0, 1, 0, 0, 0);
    go();
    // R1: over-range write ignored, then wrong length
    wr_key(17);
    check("R1 over-range ignored", int'(key_size), 16);
    wr_key(8);
    go();
    check("R4 key error latched", int'(err_cause), 1);
    clr(); cyc();
    // R5: reserved codes with a bad key report only mode
    wr_mode(1, 0, 0, 0, 0, 0);
    go();
    check("R5 mode only", int'(err_cause), 2);
    wr_key(16);
    wr_mode(3, 0, 0, 0, 0, 0);
    go();
    clr(); cyc();
    // R6: framing conflict, then single flag is legal
    wr_mode(0, 1, 0, 0, 1, 1);
    go();
    check("R6 conflict latched", int'(err_cause), 4);
    clr();
    wr_mode(0, 1, 0, 0, 1, 0);
    go();
    // R7: mismatch counted only for integrity with compare on
    wr_mode(2, 0, 0, 1, 0, 0);
    icv(32'h1234, 32'h1234);
    check("R7 match no error", int'(err_cause), 0);
    icv(32'h1234, 32'h1235);
    check("R7 mismatch flagged", int'(err_cause), 8);
    clr();
    wr_mode(0, 0, 0, 1, 0, 0);
    icv(5, 6);
    wr_mode(2, 0, 0, 0, 0, 0);
    icv(5, 6);
    check("R7 gated no error", int'(err_cause), 0);
    // R8: accumulate, and clear with a same-cycle new cause
    wr_key(4);
    go();
    wr_mode(1, 0, 0, 0, 0, 0);
    go();
    check("R8 accumulate", int'(err_cause), 3);
    err_clr = 1; start = 1; cyc(); err_clr = 0; start = 0; cyc();
    check("R8 new cause survives clear", int'(err_cause), 2);
    clr(); cyc();
    // R11: same-cycle write does not affect the start it accompanies
    wr_key(16);
    mode_alg = 2'd2; mode_we = 1; start = 1; cyc(); mode_we = 0; start = 0; cyc();
    check("R11 old settings used", int'(err_cause), 2);
    go();
    clr();
    // R2: reinit beats a same-cycle write
    ksz_wdata = 5'd12; ksz_we = 1; reinit = 1; cyc(); ksz_we = 0; reinit = 0; cyc();
    check("R2 reinit wins", int'(key_size), 0);
    repeat (2) cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule